// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block watches two external interrupt pins on behalf of a small CPU core. Each pin is first brought into the clock domain through a synchronizer. A per-pin trigger mode then picks which condition on the pin raises an interrupt: a low level, any change, a falling edge or a rising edge. In the edge and change modes the event is caught in a sticky flag. In low-level mode the flag is forced to zero and the live, synchronized pin level drives the request directly.

A pending source only becomes a request when both the global interrupt enable and that pin's own enable are 1. The block presents one registered request with a vector number: vector 1 for pin 0 and vector 2 for pin 1, with pin 0 winning when both are pending. Request and vector hold steady until the core acknowledges them. The acknowledge clears the flag of the served pin. Software sees both flags in the upper two bits of a byte-wide register and clears them by writing ones.

Top module: `ext_irq_unit`

## Requirements
- R1: After the synchronous reset, both flags read as zero, the register reads 8'h00 and `irq_req_o` is 0.
- R2: A pin change applied between clock edges becomes visible in the flag register and on `irq_req_o` after the third rising edge, and not after the second. Pin levels count as low at reset.
- R3: Mode code per pin (bits [2i+1:2i] of `mode_i`): 2'b01 sets the flag on any change, 2'b10 only on a 1-to-0 transition, 2'b11 only on a 0-to-1 transition. A transition that does not match leaves the flag at 0.
- R4: With mode 2'b00, the pin's flag always reads 0. A request is raised whenever the synchronized pin is low and the pin is enabled.
- R5: Pin 1's flag reads in bit 7 and pin 0's flag in bit 6. A register write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. Bits 5 to 0 always read 0.
- R6: A request is raised only while `gie_i` is 1 and the pin's bit in `pin_en_i` is 1. A flag that is set while it is gated stays pending and raises the request one edge after the gating lifts.
- R7: The vector is 1 for pin 0 and 2 for pin 1. When both pins are pending, pin 0 is presented first.
- R8: Once raised, `irq_req_o` and `irq_vec_o` stay unchanged until an edge where `irq_ack_i` is 1. That edge clears the flag of the acknowledged pin, and the request is re-evaluated at the same edge.
- R9: If a trigger on a pin falls in the same cycle as a write-one clear or an acknowledge of that pin, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 2 | Asynchronous external interrupt pins |
| mode_i | input | 4 | Trigger mode, two bits per pin |
| pin_en_i | input | 2 | Per-pin interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 8 | Write data, a one clears the matching flag |
| reg_rdata_o | output | 8 | Flag register read value |
| irq_req_o | output | 1 | Interrupt request toward the CPU |
| irq_vec_o | output | 3 | Vector number of the presented request |
| irq_ack_i | input | 1 | CPU has taken the presented vector |

## Verification
A wrong synchronizer depth or a wrong edge decoder shows up on the register read port as a flag that appears one edge early or late, or for a transition of the wrong direction. The sweep samples at both the second and the third edge after every pin transition, in every mode and on both pins, so such a fault is seen within three cycles. A stuck or stale flag leaves the request raised after the acknowledge, or leaves the wrong bit in the register. A broken hold or priority changes the vector while the request is still raised. Both show on the cycle right after the acknowledge or after the competing trigger.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_ANY  = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_mode_e;

endpackage

// File: rtl/ext_irq_sync.sv
// Synchronizer chain plus one history flop for edge detection.
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic lvl_prev_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o      = sh_q[STAGES-1];
  assign lvl_prev_o = sh_q[STAGES];

endmodule

// File: rtl/ext_irq_trig.sv
// Trigger decode and sticky flag for one pin.
module ext_irq_trig
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       lvl_i,
  input  logic       lvl_prev_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       src_next_o
);

  trig_mode_e mode;
  logic       fire;
  logic       flag_q;
  logic       flag_d;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    case (mode)
      TRIG_ANY:  fire = lvl_i ^ lvl_prev_i;
      TRIG_FALL: fire = lvl_prev_i & ~lvl_i;
      TRIG_RISE: fire = ~lvl_prev_i & lvl_i;
      default:   fire = 1'b0;
    endcase
  end

  // a new trigger beats a clear in the same cycle
  always_comb begin
    if (mode == TRIG_LOW) flag_d = 1'b0;
    else                  flag_d = fire | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  assign flag_o     = flag_q;
  assign src_next_o = (mode == TRIG_LOW) ? ~lvl_i : flag_d;

  a_r4_level_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> !flag_q);

  a_r9_trigger_wins: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_i != 2'b00) |=> flag_q);

  a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !fire) |=> !flag_q);

endmodule

// File: rtl/ext_irq_arb.sv
// Fixed-priority pick with a request held until acknowledged.
module ext_irq_arb #(
  parameter int NPINS    = 2,
  parameter int VEC_W    = 3,
  parameter int VEC_BASE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pend_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NPINS-1:0] ack_clr_o
);

  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] pick;
  logic             open_slot;

  // lowest index wins: loop downward, last hit stays
  always_comb begin
    pick = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = VEC_W'(i + VEC_BASE);
    end
  end

  assign open_slot = !req_q || ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (open_slot) begin
      req_q <= |pend_i;
      vec_q <= pick;
    end
  end

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_clr
      assign ack_clr_o[g] = ack_i && req_q && (vec_q == VEC_W'(g + VEC_BASE));
    end
  endgenerate

  assign req_o = req_q;
  assign vec_o = vec_q;

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i) |=> (req_q && $stable(vec_q)));

  a_r7_pin0_first: assert property (@(posedge clk) disable iff (rst)
    (open_slot && pend_i[0]) |=> (req_q && vec_q == VEC_W'(VEC_BASE)));

  a_r7_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (vec_q >= VEC_W'(VEC_BASE) && vec_q < VEC_W'(VEC_BASE + NPINS)));

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int NPINS       = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 1,
  parameter int VEC_W       = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   pin_en_i,
  input  logic               gie_i,
  input  logic               reg_wr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  input  logic               irq_ack_i
);

  localparam int FLAG_LSB = DW - NPINS;

  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] lvl_prev;
  logic [NPINS-1:0] flag;
  logic [NPINS-1:0] src_next;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] ack_clr;
  logic [NPINS-1:0] pend;
  logic             wdata_unused;

  assign wdata_unused = ^reg_wdata_i[FLAG_LSB-1:0];

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .d_i        (pin_i[g]),
        .lvl_o      (lvl[g]),
        .lvl_prev_o (lvl_prev[g])
      );

      assign clr[g] = (reg_wr_i && reg_wdata_i[FLAG_LSB + g]) || ack_clr[g];

      ext_irq_trig u_trig (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i[2*g +: 2]),
        .lvl_i      (lvl[g]),
        .lvl_prev_i (lvl_prev[g]),
        .clr_i      (clr[g]),
        .flag_o     (flag[g]),
        .src_next_o (src_next[g])
      );

      assign pend[g] = gie_i && pin_en_i[g] && src_next[g];
    end
  endgenerate

  ext_irq_arb #(
    .NPINS    (NPINS),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .ack_i     (irq_ack_i),
    .req_o     (irq_req_o),
    .vec_o     (irq_vec_o),
    .ack_clr_o (ack_clr)
  );

  assign reg_rdata_o = {flag, {FLAG_LSB{1'b0}}};

  a_r6_gated_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req_o) |-> $past(gie_i && (|pin_en_i)));

endmodule

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pin = 2'b00;
  logic [3:0] mode = 4'b1111;
  logic [1:0] en = 2'b00;
  logic       gie = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       req;
  logic [2:0] vec;
  logic       ack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_i(mode), .pin_en_i(en),
    .gie_i(gie), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    cyc(1);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 reset rdata", rdata, 8'h00);
    check("R1 reset req", req, 0);

    // sweep: every pin, mode and transition direction
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 2; t++) begin
          logic v0, v1, ef, er2, er3;
          v0 = (t == 1);
          v1 = ~v0;
          gie = 1'b0;
          en = 2'b00; en[p] = 1'b1;
          mode = 4'b1111; mode[2*p +: 2] = m[1:0];
          pin[p] = v0;
          cyc(5);
          wr_reg(8'hC0);
          cyc(1);
          pin[p] = v1; gie = 1'b1;
          case (m)
            0: ef = 1'b0;
            1: ef = 1'b1;
            2: ef = (v0 == 1'b1);
            default: ef = (v0 == 1'b0);
          endcase
          er2 = (m == 0) && (v0 == 1'b0);
          er3 = (m == 0) ? 1'b1 : ef;
          cyc(2);
          check($sformatf("R2 p%0d m%0d t%0d flag at edge 2", p, m, t), rdata, 8'h00);
          check($sformatf("R2 p%0d m%0d t%0d req at edge 2", p, m, t), req, er2);
          cyc(1);
          check($sformatf("R3/R4 p%0d m%0d t%0d flag at edge 3", p, m, t),
                rdata, ef ? (8'h40 << p) : 8'h00);
          check($sformatf("R3/R4 p%0d m%0d t%0d req at edge 3", p, m, t), req, er3);
          if (er3) check($sformatf("R7 p%0d m%0d t%0d vector", p, m, t), vec, p + 1);
          gie = 1'b0;
          pulse_ack();
          wr_reg(8'hC0);
          pin[p] = 1'b0;
          cyc(5);
          wr_reg(8'hC0);
          cyc(1);
        end
      end
    end

    // R5: register clear rules, rising mode on both pins
    mode = 4'b1111; en = 2'b00; gie = 1'b0; pin = 2'b00;
    cyc(5); wr_reg(8'hC0);
    pin = 2'b11; cyc(4);
    check("R5 both flags set", rdata, 8'hC0);
    wr_reg(8'h3F);
    check("R5 zero bits no clear, low bits read 0", rdata, 8'hC0);
    wr_reg(8'h40);
    check("R5 bit 6 clears pin 0 only", rdata, 8'h80);
    wr_reg(8'h80);
    check("R5 bit 7 clears pin 1", rdata, 8'h00);

    // R6/R7/R8: gating, priority, acknowledge
    pin = 2'b00; cyc(5); wr_reg(8'hC0);
    pin = 2'b11; cyc(4);
    gie = 1'b1; en = 2'b00; cyc(2);
    check("R6 no req with pin enables off", req, 0);
    gie = 1'b0; en = 2'b11; cyc(2);
    check("R6 no req with global enable off", req, 0);
    gie = 1'b1; cyc(1);
    check("R6 req one edge after gating lifts", req, 1);
    check("R7 pin 0 first", vec, 1);
    cyc(3);
    check("R8 vector held", vec, 1);
    pulse_ack();
    check("R8 ack clears pin 0 flag", rdata, 8'h80);
    check("R8 pin 1 presented next", {req, vec}, {1'b1, 3'd2});
    pulse_ack();
    check("R8 all served rdata", rdata, 8'h00);
    check("R8 all served req", req, 0);

    // R8: hold despite higher-priority arrival
    pin = 2'b00; cyc(4);
    pin = 2'b10; cyc(3);
    check("R8 pin 1 raised", {req, vec}, {1'b1, 3'd2});
    pin = 2'b11; cyc(4);
    check("R8 pin 0 flag pending", rdata, 8'hC0);
    check("R8 vector 2 still held", {req, vec}, {1'b1, 3'd2});
    pulse_ack();
    check("R8 then pin 0", {req, vec}, {1'b1, 3'd1});
    pulse_ack();
    check("R8 idle after both", req, 0);

    // R9: trigger coincides with write-one clear
    gie = 1'b0;
    pin = 2'b00; cyc(5); wr_reg(8'hC0);
    pin[0] = 1'b1; cyc(4);
    check("R9 setup flag", rdata, 8'h40);
    mode[1:0] = 2'b01;
    pin[0] = 1'b0;
    cyc(2);
    wr_reg(8'h40);
    check("R9 flag survives write at trigger", rdata, 8'h40);
    wr_reg(8'h40);
    check("R9 plain write clears", rdata, 8'h00);

    // R9: trigger coincides with acknowledge
    gie = 1'b1; en = 2'b01;
    pin[0] = 1'b1; cyc(3);
    check("R9 ack setup req", {req, vec}, {1'b1, 3'd1});
    pin[0] = 1'b0;
    cyc(2);
    pulse_ack();
    check("R9 flag survives ack at trigger", rdata, 8'h40);
    check("R9 request re-raised", {req, vec}, {1'b1, 3'd1});
    pulse_ack();
    check("R9 plain ack clears", rdata, 8'h00);

    finish_run();
  end

endmodule